// File: doc/BRIEF.md
# Barrel Shift and Bit-Field Unit

This block is a 64-bit shift unit for a processor execution stage. Each operation carries a source operand, the current value of the destination register, a 6-bit shift amount, a 6-bit width field and four mode bits. From these it produces one 64-bit result. The unit supports five operations:

- logical shift left
- logical shift right
- arithmetic shift right
- extraction of a bit field, right-aligned with zero fill above it
- insertion of a bit field into the destination value, which leaves every destination bit outside the field as it was

Operations arrive with a one-bit valid strobe and leave with one. The unit has no back-pressure. It takes a new operation on every clock in which `in_valid` is high, and `out_valid` rises exactly `PIPE_STAGES` cycles later. The consumer must take the result in that cycle. `PIPE_STAGES` set to 1 gives the fast build, with a single output register. Set to 2, it adds a register after the shift and mask logic, which shortens the critical path. Operands that break the field rules give an undefined result value, but the valid timing does not change.

Top module: `bsfu_top`

## Requirements
- R1: With `in_side`=1 and neither `in_extract` nor `in_insert` set, the result is `in_src` shifted left by `in_shamt`, with zeros entering at bit 0.
- R2: With `in_side`=0, `in_type`=0 and neither field mode set, the result is `in_src` shifted right by `in_shamt`, with zeros entering at bit 63.
- R3: With `in_side`=0, `in_type`=1 and neither field mode set, the result is `in_src` shifted right by `in_shamt`, with copies of bit 63 of `in_src` filling the vacated upper bits. A shift amount of 0 returns `in_src` unchanged.
- R4: With `in_extract`=1, the result is `in_src` shifted right by `in_shamt` and masked to its low `in_width` bits. Bits `in_width` and above are zero. This holds for 1 <= `in_width` <= 63 and `in_width`+`in_shamt` <= 64.
- R5: With `in_insert`=1, let the mask cover bit positions `in_shamt` through `in_width` inclusive.
  - Inside the mask, the result takes (`in_src` << `in_shamt`).
  - Outside the mask, the result keeps `in_dest`.
  - This holds for `in_width` >= `in_shamt`, including a field that reaches bit 63 (`in_width`=63).
- R6: Mode bits resolve in a fixed priority:
  - `in_extract` wins over `in_insert`.
  - `in_insert` wins over `in_side`.
  - `in_side` wins over `in_type`.
  - `in_side` and `in_type` have no effect in either field mode.
- R7: Every cycle with `in_valid`=1 produces exactly one cycle of `out_valid`=1, `PIPE_STAGES` cycles later. Operations may be issued on consecutive cycles.
- R8: While `rst_n` is low, `out_valid` is 0 and `out_result` is zero.
- R9: Operands that break the field rules of R4 or R5 still produce `out_valid` with the latency of R7.
- R10: `out_result` keeps its last value in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_src | input | 64 | Source operand |
| in_dest | input | 64 | Current destination value, used by insert |
| in_shamt | input | 6 | Shift amount; field low bit position for insert |
| in_width | input | 6 | Field width for extract; field top bit position for insert |
| in_side | input | 1 | 1 = left shift, 0 = right shift |
| in_type | input | 1 | 1 = arithmetic right shift, 0 = logical |
| in_extract | input | 1 | Field extract mode |
| in_insert | input | 1 | Field insert mode |
| out_valid | output | 1 | Result valid strobe |
| out_result | output | 64 | Result |

## Verification
Two operations meet in the same cycle in two ways:

- **Mode bits collide.** Several mode bits set on one operation must resolve through the priority order and not mix.
- **Operations overlap in the pipeline.** In the two-stage build, an operation sits in the output stage while the next one enters the first stage.

The bench provokes both. It sends random, mostly back-to-back traffic to a two-stage and a one-stage instance side by side, with random combinations of mode bits. It also sends directed operations that set extract with insert, insert with side, and side with type. Each output cycle is judged against a bench model delayed by that instance's latency. The model checks both the valid strobe and the value, so any result that goes to the wrong cycle or takes the wrong mode shows up.

// File: rtl/bsfu_pkg.sv
package bsfu_pkg;

  // Resolved operation after mode-bit priority.
  typedef enum logic [2:0] {
    OP_SRL = 3'd0,
    OP_SRA = 3'd1,
    OP_SLL = 3'd2,
    OP_EXT = 3'd3,
    OP_INS = 3'd4
  } bsfu_op_e;

endpackage

// File: rtl/bsfu_decode.sv
module bsfu_decode
  import bsfu_pkg::*;
(
  input  logic     side_i,
  input  logic     type_i,
  input  logic     extract_i,
  input  logic     insert_i,
  output bsfu_op_e op_o,
  output logic     shift_left_o,
  output logic     arith_o
);

  // Fixed priority: extract, insert, side, type, then plain right shift (R6).
  always_comb begin
    if (extract_i)      op_o = OP_EXT;
    else if (insert_i)  op_o = OP_INS;
    else if (side_i)    op_o = OP_SLL;
    else if (type_i)    op_o = OP_SRA;
    else                op_o = OP_SRL;
  end

  // Insert needs the source moved up to the field; extract moves it down.
  always_comb begin
    shift_left_o = (op_o == OP_SLL) || (op_o == OP_INS);
    arith_o      = (op_o == OP_SRA);
  end

endmodule

// File: rtl/bsfu_shifter.sv
module bsfu_shifter #(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              left_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] data_o
);

  // One right-shifting log tree; left shifts reuse it via bit reversal.
  logic [DATA_W-1:0] pre;
  logic [DATA_W-1:0] level [0:AMT_W];
  logic              fill_eff;

  assign fill_eff = fill_i & ~left_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_pre
    assign pre[i] = left_i ? data_i[DATA_W-1-i] : data_i[i];
  end

  assign level[0] = pre;

  for (genvar k = 0; k < AMT_W; k++) begin : g_level
    localparam int STEP = 1 << k;
    assign level[k+1] = amt_i[k]
                      ? {{STEP{fill_eff}}, level[k][DATA_W-1:STEP]}
                      : level[k];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_post
    assign data_o[i] = left_i ? level[AMT_W][DATA_W-1-i] : level[AMT_W][i];
  end

endmodule

// File: rtl/bsfu_mask_gen.sv
module bsfu_mask_gen #(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W),
  localparam int CNT_W = AMT_W + 1
) (
  input  logic [AMT_W-1:0]  lo_i,
  input  logic [AMT_W-1:0]  hi_i,
  input  logic [AMT_W-1:0]  width_i,
  output logic [DATA_W-1:0] field_mask_o,
  output logic [DATA_W-1:0] low_mask_o
);

  // Thresholds widened by one bit so that hi+1 may equal DATA_W; the
  // thermometer for that case is all zeros rather than a wrapped value.
  logic [CNT_W-1:0] lo_ext;
  logic [CNT_W-1:0] top_ext;
  logic [CNT_W-1:0] w_ext;

  assign lo_ext  = {1'b0, lo_i};
  assign top_ext = {1'b0, hi_i} + CNT_W'(1);
  assign w_ext   = {1'b0, width_i};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [CNT_W-1:0] POS = CNT_W'(i);
    // bits at or above lo, minus bits at or above hi+1
    assign field_mask_o[i] = (POS >= lo_ext) ^ (POS >= top_ext);
    assign low_mask_o[i]   = (POS < w_ext);
  end

endmodule

// File: rtl/bsfu_merge.sv
module bsfu_merge
  import bsfu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  bsfu_op_e          op_i,
  input  logic [DATA_W-1:0] shifted_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic [DATA_W-1:0] field_mask_i,
  input  logic [DATA_W-1:0] low_mask_i,
  output logic [DATA_W-1:0] result_o
);

  always_comb begin
    unique case (op_i)
      OP_EXT:  result_o = shifted_i & low_mask_i;
      OP_INS:  result_o = (shifted_i & field_mask_i) | (dest_i & ~field_mask_i);
      default: result_o = shifted_i;
    endcase
  end

endmodule

// File: rtl/bsfu_top.sv
module bsfu_top
  import bsfu_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int PIPE_STAGES = 2,
  localparam int AMT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_dest,
  input  logic [AMT_W-1:0]  in_shamt,
  input  logic [AMT_W-1:0]  in_width,
  input  logic              in_side,
  input  logic              in_type,
  input  logic              in_extract,
  input  logic              in_insert,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);

  // ---------------- stage A: decode, shift, masks ----------------
  bsfu_op_e          a_op;
  logic              a_left;
  logic              a_arith;
  logic [DATA_W-1:0] a_shifted;
  logic [DATA_W-1:0] a_fmask;
  logic [DATA_W-1:0] a_lmask;

  bsfu_decode u_decode (
    .side_i       (in_side),
    .type_i       (in_type),
    .extract_i    (in_extract),
    .insert_i     (in_insert),
    .op_o         (a_op),
    .shift_left_o (a_left),
    .arith_o      (a_arith)
  );

  bsfu_shifter #(.DATA_W(DATA_W)) u_shifter (
    .data_i (in_src),
    .amt_i  (in_shamt),
    .left_i (a_left),
    .fill_i (a_arith & in_src[DATA_W-1]),
    .data_o (a_shifted)
  );

  bsfu_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .lo_i         (in_shamt),
    .hi_i         (in_width),
    .width_i      (in_width),
    .field_mask_o (a_fmask),
    .low_mask_o   (a_lmask)
  );

  // ---------------- optional mid register ----------------
  logic              m_valid;
  bsfu_op_e          m_op;
  logic [DATA_W-1:0] m_shifted;
  logic [DATA_W-1:0] m_dest;
  logic [DATA_W-1:0] m_fmask;
  logic [DATA_W-1:0] m_lmask;

  if (PIPE_STAGES >= 2) begin : g_two_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_valid   <= 1'b0;
        m_op      <= OP_SRL;
        m_shifted <= '0;
        m_dest    <= '0;
        m_fmask   <= '0;
        m_lmask   <= '0;
      end else begin
        m_valid <= in_valid;
        if (in_valid) begin
          m_op      <= a_op;
          m_shifted <= a_shifted;
          m_dest    <= in_dest;
          m_fmask   <= a_fmask;
          m_lmask   <= a_lmask;
        end
      end
    end
  end else begin : g_one_stage
    always_comb begin
      m_valid   = in_valid;
      m_op      = a_op;
      m_shifted = a_shifted;
      m_dest    = in_dest;
      m_fmask   = a_fmask;
      m_lmask   = a_lmask;
    end
  end

  // ---------------- stage B: merge and output register ----------------
  logic [DATA_W-1:0] b_result;

  bsfu_merge #(.DATA_W(DATA_W)) u_merge (
    .op_i         (m_op),
    .shifted_i    (m_shifted),
    .dest_i       (m_dest),
    .field_mask_i (m_fmask),
    .low_mask_i   (m_lmask),
    .result_o     (b_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= m_valid;
      if (m_valid) out_result <= b_result;
    end
  end

endmodule

// File: rtl/bsfu_checker.sv
module bsfu_checker #(
  parameter int DATA_W      = 64,
  parameter int PIPE_STAGES = 2,
  localparam int AMT_W      = $clog2(DATA_W),
  localparam int LAT        = (PIPE_STAGES >= 2) ? 2 : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_src,
  input logic [DATA_W-1:0] in_dest,
  input logic [AMT_W-1:0]  in_shamt,
  input logic [AMT_W-1:0]  in_width,
  input logic              in_side,
  input logic              in_type,
  input logic              in_extract,
  input logic              in_insert,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result
);

  // Delay line of the presented operation, aligned to the output.
  logic [LAT-1:0]             v_q;
  logic [LAT-1:0][DATA_W-1:0] src_q;
  logic [LAT-1:0][DATA_W-1:0] dst_q;
  logic [LAT-1:0][AMT_W-1:0]  amt_q;
  logic [LAT-1:0][AMT_W-1:0]  wid_q;
  logic [LAT-1:0][3:0]        mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      amt_q  <= '0;
      wid_q  <= '0;
      mode_q <= '0;
    end else begin
      for (int k = 0; k < LAT; k++) begin
        if (k == 0) begin
          v_q[0]    <= in_valid;
          src_q[0]  <= in_src;
          dst_q[0]  <= in_dest;
          amt_q[0]  <= in_shamt;
          wid_q[0]  <= in_width;
          mode_q[0] <= {in_extract, in_insert, in_side, in_type};
        end else begin
          v_q[k]    <= v_q[k-1];
          src_q[k]  <= src_q[k-1];
          dst_q[k]  <= dst_q[k-1];
          amt_q[k]  <= amt_q[k-1];
          wid_q[k]  <= wid_q[k-1];
          mode_q[k] <= mode_q[k-1];
        end
      end
    end
  end

  logic [DATA_W-1:0] c_src, c_dst;
  logic [AMT_W-1:0]  c_amt, c_wid;
  logic              c_ext, c_ins, c_side, c_type;
  logic [DATA_W-1:0] all_ones;

  assign all_ones = '1;
  assign c_src  = src_q[LAT-1];
  assign c_dst  = dst_q[LAT-1];
  assign c_amt  = amt_q[LAT-1];
  assign c_wid  = wid_q[LAT-1];
  assign c_ext  = mode_q[LAT-1][3];
  assign c_ins  = mode_q[LAT-1][2];
  assign c_side = mode_q[LAT-1][1];
  assign c_type = mode_q[LAT-1][0];

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_q[LAT-1]);

  assert_left_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !c_ext && !c_ins && c_side) |-> out_result == (c_src << c_amt));

  assert_logical_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !c_ext && !c_ins && !c_side && !c_type && c_amt != '0)
      |-> !out_result[DATA_W-1]);

  assert_arith_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !c_ext && !c_ins && !c_side && c_type && c_src[DATA_W-1])
      |-> out_result[DATA_W-1]);

  assert_arith_zero_amt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !c_ext && !c_ins && !c_side && c_type && c_amt == '0)
      |-> out_result == c_src);

  // R6 as well: extract holds whatever the other mode bits are.
  assert_extract_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c_ext && c_wid != '0) |-> (out_result >> c_wid) == '0);

  assert_insert_keeps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !c_ext && c_ins && c_wid >= c_amt)
      |-> ((out_result ^ c_dst) & ~(all_ones << c_amt)) == '0);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));

endmodule

bind bsfu_top bsfu_checker #(.DATA_W(DATA_W), .PIPE_STAGES(PIPE_STAGES)) u_bsfu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_src     (in_src),
  .in_dest    (in_dest),
  .in_shamt   (in_shamt),
  .in_width   (in_width),
  .in_side    (in_side),
  .in_type    (in_type),
  .in_extract (in_extract),
  .in_insert  (in_insert),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/tb_bsfu_top.sv
module tb_bsfu_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_src = '0, in_dest = '0;
  logic [5:0]  in_shamt = '0, in_width = '0;
  logic        in_side = 1'b0, in_type = 1'b0, in_extract = 1'b0, in_insert = 1'b0;
  logic        v2, v1;
  logic [63:0] r2, r1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsfu_top #(.DATA_W(64), .PIPE_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src), .in_dest(in_dest),
    .in_shamt(in_shamt), .in_width(in_width), .in_side(in_side), .in_type(in_type),
    .in_extract(in_extract), .in_insert(in_insert), .out_valid(v2), .out_result(r2));

  bsfu_top #(.DATA_W(64), .PIPE_STAGES(1)) dut_fast (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src), .in_dest(in_dest),
    .in_shamt(in_shamt), .in_width(in_width), .in_side(in_side), .in_type(in_type),
    .in_extract(in_extract), .in_insert(in_insert), .out_valid(v1), .out_result(r1));

  typedef struct {
    logic        valid;
    logic        known;
    logic [63:0] res;
    string       req;
  } exp_t;

  exp_t p1, p2a, p2b;
  logic [63:0] last1 = '0, last2 = '0;

  function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] d,
                                        input logic [5:0] a, input logic [5:0] w,
                                        input logic side, input logic typ,
                                        input logic ext, input logic ins);
    logic [63:0] ones;
    logic [63:0] m;
    ones = '1;
    if (ext) return (s >> a) & ~(ones << w);
    if (ins) begin
      m = (ones << (int'(w) + 1)) ^ (ones << a);
      return ((s << a) & m) | (d & ~m);
    end
    if (side) return s << a;
    if (typ)  return 64'($signed(s) >>> a);
    return s >> a;
  endfunction

  function automatic bit legal(input logic [5:0] a, input logic [5:0] w,
                               input logic ext, input logic ins);
    if (ext) return (w != 0) && (int'(w) + int'(a) <= 64);
    if (ins) return w >= a;
    return 1'b1;
  endfunction

  function automatic string req_of(input logic side, input logic typ,
                                   input logic ext, input logic ins);
    if (ext && (ins || side || typ)) return "R6";
    if (ins && (side || typ))        return "R6";
    if (!ext && !ins && side && typ) return "R6";
    if (ext)  return "R4";
    if (ins)  return "R5";
    if (side) return "R1";
    if (typ)  return "R3";
    return "R2";
  endfunction

  task automatic chk(input string req, input string who, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, who, act, exp);
    end
  endtask

  task automatic judge(input string who, input exp_t e, input logic v,
                       input logic [63:0] r, inout logic [63:0] last);
    chk(e.known ? "R7" : "R9", {who, " valid"}, 64'(v), 64'(e.valid));
    if (e.valid) begin
      if (e.known) begin
        chk(e.req, {who, " result"}, r, e.res);
        last = e.res;
      end else begin
        last = r;
      end
    end else begin
      chk("R10", {who, " hold"}, r, last);
    end
  endtask

  task automatic step(input logic vld, input logic [63:0] s, input logic [63:0] d,
                      input logic [5:0] a, input logic [5:0] w, input logic side,
                      input logic typ, input logic ext, input logic ins);
    exp_t n;
    @(negedge clk);
    judge("fast", p1, v1, r1, last1);
    judge("pipe", p2b, v2, r2, last2);
    in_valid = vld; in_src = s; in_dest = d; in_shamt = a; in_width = w;
    in_side = side; in_type = typ; in_extract = ext; in_insert = ins;
    n.valid = vld;
    n.known = legal(a, w, ext, ins);
    n.res   = model(s, d, a, w, side, typ, ext, ins);
    n.req   = req_of(side, typ, ext, ins);
    p2b = p2a; p2a = n; p1 = n;
  endtask

  task automatic idle();
    step(1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] s, d;
    logic [5:0]  a, w;
    logic        sd, ty, ex, is, vl;
    int          mode;
    void'($urandom(32'd20240611));
    p1  = '{1'b0, 1'b1, 64'd0, "R8"};
    p2a = p1;
    p2b = p1;
    repeat (3) @(posedge clk);
    // R8: outputs cleared while reset is held
    @(negedge clk);
    chk("R8", "pipe valid", 64'(v2), 64'd0);
    chk("R8", "pipe result", r2, 64'd0);
    chk("R8", "fast valid", 64'(v1), 64'd0);
    chk("R8", "fast result", r1, 64'd0);
    rst_n = 1'b1;

    // directed corners, issued back to back
    step(1, 64'h8000_0000_0000_0001, '0, 6'd0,  '0, 1, 0, 0, 0);           // R1 by 0
    step(1, 64'h8000_0000_0000_0001, '0, 6'd63, '0, 1, 0, 0, 0);           // R1 by 63
    step(1, 64'hF000_0000_0000_0000, '0, 6'd63, '0, 0, 0, 0, 0);           // R2 by 63
    step(1, 64'h8000_0000_0000_0000, '0, 6'd63, '0, 0, 1, 0, 0);           // R3 all ones
    step(1, 64'h8123_4567_89AB_CDEF, '0, 6'd0,  '0, 0, 1, 0, 0);           // R3 amount 0
    step(1, 64'h7FFF_0000_0000_0000, '0, 6'd4,  '0, 0, 1, 0, 0);           // R3 positive
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, '0, 6'd1,  6'd63, 0, 0, 1, 0);        // R4 widest
    step(1, 64'h8000_0000_0000_0000, '0, 6'd63, 6'd1, 1, 1, 1, 0);         // R4/R6 top bit
    step(1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 6'd63, 0, 0, 0, 1); // R5 full
    step(1, 64'h0000_0000_0000_0001, 64'h0, 6'd63, 6'd63, 0, 0, 0, 1);     // R5 top bit only
    step(1, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 6'd0, 0, 0, 0, 1); // R5 bit 0
    step(1, 64'h0000_0000_0000_00FF, 64'h0, 6'd56, 6'd63, 0, 0, 0, 1);     // R5 reaching MSB
    step(1, 64'hDEAD_BEEF_0000_FFFF, 64'h1111_2222_3333_4444, 6'd8, 6'd15, 0, 0, 1, 1); // R6 E over I
    step(1, 64'hDEAD_BEEF_0000_FFFF, 64'h1111_2222_3333_4444, 6'd8, 6'd15, 1, 1, 0, 1); // R6 I over S
    step(1, 64'h8000_0000_0000_00F0, '0, 6'd4, '0, 1, 1, 0, 0);            // R6 S over T
    step(1, 64'h1234, 64'h5678, 6'd20, 6'd5, 0, 0, 0, 1);                  // R9 illegal insert
    step(1, 64'h1234, 64'h5678, 6'd40, 6'd40, 0, 0, 1, 0);                 // R9 illegal extract
    idle(); idle(); idle();

    for (int i = 0; i < N_RANDOM; i++) begin
      s  = {$urandom(), $urandom()};
      d  = {$urandom(), $urandom()};
      a  = 6'($urandom_range(0, 63));
      w  = 6'($urandom_range(0, 63));
      sd = 0; ty = 0; ex = 0; is = 0;
      vl = ($urandom_range(0, 3) != 0);
      mode = $urandom_range(0, 5);
      case (mode)
        0: sd = 1;
        1: ;
        2: ty = 1;
        3: begin
          ex = 1;
          if ($urandom_range(0, 15) != 0) begin
            w = 6'($urandom_range(1, 63));
            a = 6'($urandom_range(0, 64 - int'(w)));
          end
        end
        4: begin
          is = 1;
          if ($urandom_range(0, 15) != 0) w = 6'($urandom_range(int'(a), 63));
        end
        default: begin
          {ex, is, sd, ty} = 4'($urandom_range(0, 15));
        end
      endcase
      step(vl, s, d, a, w, sd, ty, ex, is);
    end
    idle(); idle(); idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule